// File: doc/BRIEF.md
# PHY Management Serial Master

This block lets a host read and write the registers of an Ethernet PHY over the two-wire management bus: a clock line (MDC) and a bidirectional data line whose output, output-enable and input appear as separate pins. The host programs it through a small write-only register port. It picks a clock ratio, loads a combined PHY/register address and then starts a transfer. A write transfer starts when the 16-bit write data is written. A read transfer starts when the read command bit is set. A busy flag covers the whole transfer. The 16-bit read result is shown on a dedicated output.

MDC runs only during a transfer. It rests low otherwise. Its period comes from a fixed set of fifteen uneven ratios, chosen by a 4-bit selector. To pick a selector, software finds the smallest ratio that is at least the system clock frequency divided by the highest MDC frequency it allows, and writes that ratio's position plus one. Each transfer is a 64-bit clause-22 frame sent MSB first. A management-reset bit forces the interface idle for as long as it is set.

Top module: `mdm_master`

## Requirements
- R1: After reset, busy, mdc, mdio_o and mdio_oe are 0 and rd_data is 0.
- R2: Selector values 1 to 15 choose a ratio from the list 4, 6, 8, 10, 14, 20, 28, 36, 40, 44, 48, 52, 56, 60, 64 (value 1 picks 4, value 15 picks 64). Selector 0 also picks 4. One MDC period is that many clock cycles, so busy stays high for exactly 64 times the ratio. The selector is held in register 0 (wr_sel=0), bits [3:0].
- R3: A write frame is sent MSB first as 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, and then the 16 data bits. mdio_oe is high for all 64 bits.
- R4: The address register (wr_sel=1) holds the register number in bits [4:0] and the PHY address in bits [9:5]. Writing the data register (wr_sel=2) starts a write transfer that uses that data and the stored address.
- R5: A read frame carries opcode 10. mdio_oe falls at the MDC falling edge that ends bit 45, so the master releases the line for the two turnaround bits and the 16 data bits. mdio_oe is low whenever busy is low.
- R6: Read data is sampled from mdio_i at MDC rising edges, MSB first. rd_data takes the 16 sampled bits when busy falls.
- R7: A read starts when the command register (wr_sel=3) is written with bit 0 set while its stored read bit is 0. Writing 1 again before the host writes 0 starts nothing.
- R8: busy stays high from the start of a frame until its last MDC falling edge. MDC is low whenever busy is low. mdio_o changes during a frame only at MDC falling edges.
- R9: A data-register write or a read command that arrives while busy is high has no effect on the frame in flight, and it starts no later frame.
- R10: Bit 15 of register 0 is the management reset. While it is set, any frame is aborted on the next cycle (busy and mdc low), and data writes and read commands are ignored. Clearing the bit releases the interface.
- R11: rd_data does not change while a frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 config, 1 address, 2 write data, 3 command |
| wr_data | input | 16 | Register write value |
| busy | output | 1 | Transfer in progress |
| rd_data | output | 16 | Result of the last completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The bound assertions check, on every cycle, the relations that hold between outputs at all times. MDC and the data enable rest low when the block is idle. The data output moves only on MDC falling edges. The enable falls only at a falling edge. The read result holds steady during a frame. Management reset empties the pipeline on the next cycle. Only the bench's scenarios can show that the frame contents are right bit for bit, that each selector gives its ratio from the uneven list, that read data is assembled MSB first, and that commands arriving during a frame, a read bit that is never cleared, or a reset are dropped with no frame sent later.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned SEL_W      = 4;
  localparam int unsigned HALF_W     = 6;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 16;

  typedef enum logic [1:0] {
    REG_CFG   = 2'd0,
    REG_ADDR  = 2'd1,
    REG_WDATA = 2'd2,
    REG_CMD   = 2'd3
  } reg_sel_e;

  function automatic int unsigned ratio_of(input int unsigned idx);
    case (idx)
      0: return 4;    1: return 6;    2: return 8;    3: return 10;
      4: return 14;   5: return 20;   6: return 28;   7: return 36;
      8: return 40;   9: return 44;   10: return 48;  11: return 52;
      12: return 56;  13: return 60;  default: return 64;
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] half_of(input logic [SEL_W-1:0] sel);
    int unsigned idx;
    idx = (sel == '0) ? 0 : int'(sel) - 1;
    return HALF_W'(ratio_of(idx) / 2);
  endfunction
endpackage

// File: rtl/mdm_clkgen.sv
module mdm_clkgen
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_p,
  output logic             fall_p
);
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt;
  logic              wrap;

  assign wrap   = run && (cnt == half_q - HALF_W'(1));
  assign rise_p = wrap && !mdc;
  assign fall_p = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(2);
      cnt    <= '0;
      mdc    <= 1'b0;
    end else begin
      if (load) half_q <= half_of(sel);
      if (!run) begin
        cnt <= '0;
        mdc <= 1'b0;
      end else if (wrap) begin
        cnt <= '0;
        mdc <= !mdc;
      end else begin
        cnt <= cnt + HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdm_frame.sv
module mdm_frame
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned CNT_W   = $clog2(FRAME_BITS);
  localparam int unsigned DATA_LO = FRAME_BITS - DATA_W;
  localparam int unsigned TA_LO   = DATA_LO - 2;

  logic [FRAME_BITS-1:0] sreg;
  logic [CNT_W-1:0]      bit_cnt;
  logic [DATA_W-1:0]     rshift;
  logic                  rd_mode;
  logic [FRAME_BITS-1:0] frame;

  always_comb begin
    frame = {{32{1'b1}}, 2'b01,
             is_read ? 2'b10 : 2'b01,
             phy_addr, reg_addr,
             is_read ? 2'b11 : 2'b10,
             is_read ? {DATA_W{1'b0}} : wdata};
  end

  assign mdio_o = sreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      bit_cnt <= '0;
      rshift  <= '0;
      rd_mode <= 1'b0;
      busy    <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (abort) begin
      sreg    <= '0;
      bit_cnt <= '0;
      busy    <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        sreg    <= frame;
        bit_cnt <= '0;
        rd_mode <= is_read;
        busy    <= 1'b1;
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_p && rd_mode && (bit_cnt >= CNT_W'(DATA_LO)))
        rshift <= {rshift[DATA_W-2:0], mdio_i};
      if (fall_p) begin
        if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          if (rd_mode) rd_data <= rshift;
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
          sreg    <= {sreg[FRAME_BITS-2:0], 1'b0};
          if (rd_mode && (bit_cnt == CNT_W'(TA_LO - 1))) mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdm_master.sv
module mdm_master
  import mdm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [SEL_W-1:0]    div_sel;
  logic                mgmt_rst;
  logic [2*ADDR_W-1:0] addr_q;
  logic                rd_cmd;
  logic                idle_ok;
  logic                start_wr;
  logic                start_rd;
  logic                rise_p;
  logic                fall_p;
  reg_sel_e            sel;

  assign sel      = reg_sel_e'(wr_sel);
  assign idle_ok  = !busy && !mgmt_rst;
  assign start_wr = wr_en && (sel == REG_WDATA) && idle_ok;
  assign start_rd = wr_en && (sel == REG_CMD) && wr_data[0] && !rd_cmd && idle_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel  <= '0;
      mgmt_rst <= 1'b0;
      addr_q   <= '0;
      rd_cmd   <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        REG_CFG: begin
          div_sel  <= wr_data[SEL_W-1:0];
          mgmt_rst <= wr_data[15];
        end
        REG_ADDR: addr_q <= wr_data[2*ADDR_W-1:0];
        REG_CMD:  if (idle_ok) rd_cmd <= wr_data[0];
        default: ;
      endcase
    end
  end

  mdm_clkgen u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy && !mgmt_rst),
    .load   (start_wr || start_rd),
    .sel    (div_sel),
    .mdc    (mdc),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  mdm_frame u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (mgmt_rst),
    .start    (start_wr || start_rd),
    .is_read  (start_rd),
    .phy_addr (addr_q[2*ADDR_W-1:ADDR_W]),
    .reg_addr (addr_q[ADDR_W-1:0]),
    .wdata    (wr_data),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/mdm_checker.sv
module mdm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mgmt_rst,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_data
);
  AST_RST_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_rst |=> !busy);  // R10
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);  // R8
  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);  // R5
  AST_MDIO_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));  // R8
  AST_OE_DROP_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdio_oe) && busy) |-> $fell(mdc));  // R5
  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_data));  // R11
endmodule

bind mdm_master mdm_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mgmt_rst (mgmt_rst),
  .busy     (busy),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .rd_data  (rd_data)
);

// File: tb/sim_mdm_master.sv
module sim_mdm_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        phy_drv = 1'b1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  int          nrise = 0;
  logic [15:0] phy_val = 16'h0000;

  always #4 clk = !clk;

  mdm_master u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(phy_drv)
  );

  // PHY model: capture the line on MDC rise, drive read data after MDC fall
  always @(posedge mdc) begin
    cap   <= {cap[62:0], mdio_oe ? mdio_o : phy_drv};
    oecap <= {oecap[62:0], mdio_oe};
    nrise <= nrise + 1;
  end
  always @(negedge mdc) begin
    if (nrise % 64 >= 48) phy_drv <= phy_val[63 - (nrise % 64)];
    else phy_drv <= 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts negedges with busy high, starting at the current negedge
  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic t_reset();
    check(!busy && !mdc && !mdio_o && !mdio_oe, "R1 idle outputs",
          {busy, mdc, mdio_o, mdio_oe}, 0);
    check(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
  endtask

  task automatic t_write(input logic [3:0] dsel, input int ratio, input logic [4:0] p,
                         input logic [4:0] r, input logic [15:0] d);
    int n, base;
    reg_wr(2'd0, {12'h0, dsel});
    reg_wr(2'd1, {6'h0, p, r});
    base = nrise;
    reg_wr(2'd2, d);
    check(busy == 1'b1, "R4 busy after data write", busy, 1);
    count_busy(n);
    check(n == 64 * ratio, "R2 busy cycles for ratio", n, 64 * ratio);
    check(nrise - base == 64, "R8 one frame of MDC edges", nrise - base, 64);
    check(cap == wr_frame(p, r, d), "R3 write frame bits", cap, wr_frame(p, r, d));
    check(oecap == {64{1'b1}}, "R3 oe held in write", oecap, {64{1'b1}});
  endtask

  task automatic t_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] v);
    int n;
    logic [45:0] hdr;
    hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    phy_val = v;
    reg_wr(2'd0, 16'h0001);
    reg_wr(2'd1, {6'h0, p, r});
    reg_wr(2'd3, 16'h0001);
    check(busy == 1'b1, "R7 read started", busy, 1);
    count_busy(n);
    check(cap[63:18] == hdr, "R5 read header", cap[63:18], hdr);
    check(oecap == {{46{1'b1}}, 18'h0}, "R5 oe released at turnaround", oecap,
          {{46{1'b1}}, 18'h0});
    check(rd_data == v, "R6 read data", rd_data, v);
    check(!mdio_oe && !mdc, "R8 idle after read", {mdio_oe, mdc}, 0);
  endtask

  task automatic t_read_held();
    int base;
    base = nrise;
    reg_wr(2'd3, 16'h0001);
    repeat (20) @(negedge clk);
    check(!busy && nrise == base, "R7 held read bit starts nothing", busy, 0);
    reg_wr(2'd3, 16'h0000);
    phy_val = 16'h3C5A;
    reg_wr(2'd3, 16'h0001);
    check(busy == 1'b1, "R7 read after clear", busy, 1);
    while (busy) @(negedge clk);
    check(rd_data == 16'h3C5A, "R6 second read data", rd_data, 16'h3C5A);
    reg_wr(2'd3, 16'h0000);
  endtask

  task automatic t_busy_ignore();
    int base;
    reg_wr(2'd0, 16'h0001);
    reg_wr(2'd1, {6'h0, 5'd3, 5'd9});
    base = nrise;
    reg_wr(2'd2, 16'hA55A);
    repeat (10) @(negedge clk);
    reg_wr(2'd2, 16'h1234);
    reg_wr(2'd3, 16'h0001);
    while (busy) @(negedge clk);
    check(cap == wr_frame(5'd3, 5'd9, 16'hA55A), "R9 frame unchanged", cap,
          wr_frame(5'd3, 5'd9, 16'hA55A));
    repeat (30) @(negedge clk);
    check(!busy && nrise - base == 64, "R9 no later frame", nrise - base, 64);
    check(rd_data == 16'h3C5A, "R9 rd_data untouched", rd_data, 16'h3C5A);
  endtask

  task automatic t_mgmt_reset();
    int base;
    reg_wr(2'd0, 16'h0002);
    reg_wr(2'd2, 16'hFFFF);
    repeat (100) @(negedge clk);
    reg_wr(2'd0, 16'h8002);
    @(negedge clk);
    check(!busy && !mdc && !mdio_oe, "R10 abort", {busy, mdc, mdio_oe}, 0);
    base = nrise;
    reg_wr(2'd2, 16'h00FF);
    reg_wr(2'd3, 16'h0001);
    repeat (20) @(negedge clk);
    check(!busy && nrise == base, "R10 commands ignored in reset", busy, 0);
    reg_wr(2'd0, 16'h0002);
    reg_wr(2'd2, 16'h0F0F);
    check(busy == 1'b1, "R10 released", busy, 1);
    while (busy) @(negedge clk);
    check(cap[15:0] == 16'h0F0F, "R10 frame after release", cap[15:0], 16'h0F0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(4'd1, 4, 5'd1, 5'd0, 16'h8000);
    t_write(4'd0, 4, 5'd31, 5'd31, 16'h0001);
    t_write(4'd5, 14, 5'd10, 5'd21, 16'hBEEF);
    t_write(4'd15, 64, 5'd17, 5'd4, 16'h1234);
    t_read(5'd2, 5'd1, 16'hC3A5);
    t_read_held();
    t_busy_ignore();
    t_mgmt_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule